// File: doc/BRIEF.md
# SPI Bus Monitor Byte Decoder

A passive observer for a four-wire SPI bus. It never drives the bus. It oversamples the serial clock, the active-low select and both data lines in a faster system clock domain. From a static clock-polarity and clock-phase setting it chooses which serial clock transition carries data. It then rebuilds the bytes on the controller-out line and on the controller-in line as two independent streams.

Each stream presents a byte, a one-cycle valid strobe, a start-of-frame flag, an end-of-frame flag and a pending-bit count. A bit's value comes only from the data level at a sampling edge inside the select window. Whatever the data line does after the last sampling edge, or while select is high, has no effect on any decoded value. This includes staying high, staying low, floating or pulsing. A frame that ends with a run of ones therefore decodes as ones. Frames of any length are cut into consecutive bytes. A frame that stops part-way through a byte yields a short, right-aligned byte together with its bit count.

Top module: `spi_mon_decoder`

## Requirements
- R1: The sampling edge is the rising serial clock edge when polarity equals phase (0/0 or 1/1), and the falling edge when they differ (0/1 or 1/0).
- R2: Bits are assembled most-significant first. The valid strobe is high for one cycle. It is seen at the third system clock rising edge after the eighth sampling edge of a byte appears on sclk_i.
- R3: Each bit is the data level at its sampling edge. The data level after the final sampling edge (high, low or pulsed) never changes a decoded value, so trailing ones decode as ones.
- R4: A frame is split into consecutive 8-bit bytes whatever its length. A full byte has valid high, eof low and count 0.
- R5: The first output of each frame, whether a full or a partial byte, carries sof. No other output carries it, and sof is never high without valid.
- R6: If select rises with 1 to 7 bits pending, the block emits one output with valid and eof high, count equal to the pending bit number, and the pending bits right-aligned in the byte (the last received bit in bit 0).
- R7: If select rises on a byte boundary after at least one bit, the block emits a single end marker: eof high, valid low, count 0.
- R8: Serial clock edges while select is high are ignored. A falling select clears all pending bits and starts a new frame.
- R9: The two data lines decode independently, each into its own stream, from the same sampling edges.
- R10: After reset, all stream outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, faster than the serial clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpol_i | input | 1 | Serial clock idle level |
| cpha_i | input | 1 | Clock phase: 0 samples on leading edge, 1 on trailing edge |
| sclk_i | input | 1 | Observed serial clock |
| cs_ni | input | 1 | Observed select, active low |
| mosi_i | input | 1 | Observed controller-out data |
| miso_i | input | 1 | Observed controller-in data |
| mosi_data_o | output | 8 | Controller-out byte |
| mosi_valid_o | output | 1 | Controller-out byte strobe |
| mosi_sof_o | output | 1 | Controller-out first output of frame |
| mosi_eof_o | output | 1 | Controller-out end of frame |
| mosi_cnt_o | output | 3 | Controller-out pending bits at frame end, 0 for a full byte |
| miso_data_o | output | 8 | Controller-in byte |
| miso_valid_o | output | 1 | Controller-in byte strobe |
| miso_sof_o | output | 1 | Controller-in first output of frame |
| miso_eof_o | output | 1 | Controller-in end of frame |
| miso_cnt_o | output | 3 | Controller-in pending bits at frame end, 0 for a full byte |

## Verification
A wrong bit counter shows at the ports within one byte time. The strobe then moves off the third-cycle slot after the eighth edge, or a frame gives the wrong number of outputs with the wrong count at its end. A bad shift register or a sampled data level taken from the wrong cycle corrupts the first byte that follows. Trailing-level sweeps show any dependence on post-frame data. Stale frame state (first-byte flag, pending bits) shows on the next frame's first output or end marker.

// File: rtl/spi_mon_pkg.sv
package spi_mon_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CNT_W  = $clog2(BYTE_W);

  typedef enum logic {
    EDGE_FALL = 1'b0,
    EDGE_RISE = 1'b1
  } samp_edge_e;

  typedef struct packed {
    logic [BYTE_W-1:0] data;
    logic              valid;
    logic              sof;
    logic              eof;
    logic [CNT_W-1:0]  cnt;
  } lane_out_t;
endpackage

// File: rtl/spi_mon_sync.sv
module spi_mon_sync #(
  parameter int unsigned     W       = 4,
  parameter int unsigned     STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= {STAGES{RST_VAL}};
    else         stg_q <= {stg_q[STAGES-2:0], d_i};
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/spi_mon_edge.sv
module spi_mon_edge
  import spi_mon_pkg::*;
#(
  parameter int unsigned LANES  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cpol_i,
  input  logic             cpha_i,
  input  logic             sclk_i,
  input  logic             cs_ni,
  input  logic [LANES-1:0] data_i,
  output logic             samp_o,
  output logic             cs_fall_o,
  output logic             cs_rise_o,
  output logic [LANES-1:0] data_o
);
  localparam int unsigned BUS_W = LANES + 2;
  localparam logic [BUS_W-1:0] BUS_RST = BUS_W'(2);  // select idles high

  logic [BUS_W-1:0] bus_s;
  logic sclk_s, cs_s, sclk_q, cs_q;
  logic sclk_rise, sclk_fall;
  samp_edge_e edge_sel;

  spi_mon_sync #(.W(BUS_W), .STAGES(STAGES), .RST_VAL(BUS_RST)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({data_i, cs_ni, sclk_i}),
    .q_o   (bus_s)
  );

  assign sclk_s = bus_s[0];
  assign cs_s   = bus_s[1];
  assign data_o = bus_s[2 +: LANES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
    end else begin
      sclk_q <= sclk_s;
      cs_q   <= cs_s;
    end
  end

  assign edge_sel  = (cpol_i == cpha_i) ? EDGE_RISE : EDGE_FALL;
  assign sclk_rise = sclk_s & ~sclk_q;
  assign sclk_fall = ~sclk_s & sclk_q;
  assign samp_o    = ~cs_s & ((edge_sel == EDGE_RISE) ? sclk_rise : sclk_fall);
  assign cs_fall_o = ~cs_s & cs_q;
  assign cs_rise_o = cs_s & ~cs_q;

  AST_EDGE_DIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    samp_o |-> (sclk_s == (cpol_i ~^ cpha_i)) && (sclk_q != sclk_s)); // R1
  AST_EDGE_IN_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    samp_o |-> !cs_rise_o && !cs_q); // R8
endmodule

// File: rtl/spi_mon_lane.sv
module spi_mon_lane
  import spi_mon_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      samp_i,
  input  logic      cs_fall_i,
  input  logic      cs_rise_i,
  input  logic      d_i,
  output lane_out_t out_o
);
  logic [BYTE_W-1:0] sh_q, sh_nxt;
  logic [CNT_W-1:0]  cnt_q;
  logic              first_q, any_q;
  lane_out_t         out_q;

  assign sh_nxt = {sh_q[BYTE_W-2:0], d_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q    <= '0;
      cnt_q   <= '0;
      first_q <= 1'b0;
      any_q   <= 1'b0;
      out_q   <= '0;
    end else begin
      out_q.valid <= 1'b0;
      out_q.sof   <= 1'b0;
      out_q.eof   <= 1'b0;
      if (cs_fall_i) begin
        sh_q    <= '0;
        cnt_q   <= '0;
        first_q <= 1'b1;
        any_q   <= 1'b0;
      end else if (cs_rise_i) begin
        if (any_q) begin
          out_q.eof   <= 1'b1;
          out_q.cnt   <= cnt_q;
          out_q.valid <= (cnt_q != '0);
          out_q.sof   <= (cnt_q != '0) && first_q;
          out_q.data  <= (cnt_q != '0) ? sh_q : '0;
        end
        sh_q    <= '0;
        cnt_q   <= '0;
        first_q <= 1'b0;
        any_q   <= 1'b0;
      end else if (samp_i) begin
        any_q <= 1'b1;
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CNT_W'(BYTE_W - 1)) begin
          out_q.valid <= 1'b1;
          out_q.sof   <= first_q;
          out_q.data  <= sh_nxt;
          out_q.cnt   <= '0;
          first_q     <= 1'b0;
          sh_q        <= '0;
        end else begin
          sh_q <= sh_nxt;
        end
      end
    end
  end

  assign out_o = out_q;

  AST_VALID_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_q.valid |-> $past(samp_i || cs_rise_i)); // R2
  AST_EOF_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_q.eof |-> $past(cs_rise_i)); // R6
  AST_PARTIAL_CNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_q.valid && out_q.eof) |-> out_q.cnt != '0); // R6
  AST_FULL_CNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_q.valid && !out_q.eof) |-> out_q.cnt == '0); // R4
  AST_SOF_WITH_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_q.sof |-> out_q.valid); // R5
  AST_MARKER_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_q.eof && !out_q.valid) |-> out_q.cnt == '0 && !out_q.sof); // R7
endmodule

// File: rtl/spi_mon_decoder.sv
module spi_mon_decoder
  import spi_mon_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpol_i,
  input  logic              cpha_i,
  input  logic              sclk_i,
  input  logic              cs_ni,
  input  logic              mosi_i,
  input  logic              miso_i,
  output logic [BYTE_W-1:0] mosi_data_o,
  output logic              mosi_valid_o,
  output logic              mosi_sof_o,
  output logic              mosi_eof_o,
  output logic [CNT_W-1:0]  mosi_cnt_o,
  output logic [BYTE_W-1:0] miso_data_o,
  output logic              miso_valid_o,
  output logic              miso_sof_o,
  output logic              miso_eof_o,
  output logic [CNT_W-1:0]  miso_cnt_o
);
  localparam int unsigned LANES = 2;

  logic             samp, cs_fall, cs_rise;
  logic [LANES-1:0] lane_d;
  lane_out_t        lane_out [LANES];

  spi_mon_edge #(.LANES(LANES), .STAGES(SYNC_STAGES)) u_edge (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cpol_i   (cpol_i),
    .cpha_i   (cpha_i),
    .sclk_i   (sclk_i),
    .cs_ni    (cs_ni),
    .data_i   ({miso_i, mosi_i}),
    .samp_o   (samp),
    .cs_fall_o(cs_fall),
    .cs_rise_o(cs_rise),
    .data_o   (lane_d)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    spi_mon_lane u_lane (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .samp_i   (samp),
      .cs_fall_i(cs_fall),
      .cs_rise_i(cs_rise),
      .d_i      (lane_d[g]),
      .out_o    (lane_out[g])
    );
  end

  assign mosi_data_o  = lane_out[0].data;
  assign mosi_valid_o = lane_out[0].valid;
  assign mosi_sof_o   = lane_out[0].sof;
  assign mosi_eof_o   = lane_out[0].eof;
  assign mosi_cnt_o   = lane_out[0].cnt;
  assign miso_data_o  = lane_out[1].data;
  assign miso_valid_o = lane_out[1].valid;
  assign miso_sof_o   = lane_out[1].sof;
  assign miso_eof_o   = lane_out[1].eof;
  assign miso_cnt_o   = lane_out[1].cnt;

  AST_LANES_LOCKSTEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mosi_valid_o == miso_valid_o) && (mosi_eof_o == miso_eof_o)); // R9
endmodule

// File: tb/spi_mon_decoder_test.sv
`timescale 1ns/1ps
module spi_mon_decoder_test;
  localparam int HALF = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cpol = 1'b0, cpha = 1'b0, sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0, miso = 1'b0;
  logic [7:0] mo_d, mi_d;
  logic mo_v, mo_s, mo_e, mi_v, mi_s, mi_e;
  logic [2:0] mo_c, mi_c;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;
  int cyc = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  spi_mon_decoder uut (
    .clk_i(clk), .rst_ni(rst_n), .cpol_i(cpol), .cpha_i(cpha),
    .sclk_i(sclk), .cs_ni(cs_n), .mosi_i(mosi), .miso_i(miso),
    .mosi_data_o(mo_d), .mosi_valid_o(mo_v), .mosi_sof_o(mo_s), .mosi_eof_o(mo_e), .mosi_cnt_o(mo_c),
    .miso_data_o(mi_d), .miso_valid_o(mi_v), .miso_sof_o(mi_s), .miso_eof_o(mi_e), .miso_cnt_o(mi_c)
  );

  // captured stream entries per lane
  logic [7:0] rec_d [2][16];
  logic       rec_v [2][16], rec_s [2][16], rec_e [2][16];
  logic [2:0] rec_c [2][16];
  int rec_n [2];
  int first_v_cyc, edge8_cyc;

  logic [7:0] tx [2][8];

  always @(negedge clk) begin
    if (mo_v || mo_e) begin
      if (rec_n[0] < 16) begin
        rec_d[0][rec_n[0]] = mo_d; rec_v[0][rec_n[0]] = mo_v; rec_s[0][rec_n[0]] = mo_s;
        rec_e[0][rec_n[0]] = mo_e; rec_c[0][rec_n[0]] = mo_c;
      end
      if (mo_v && first_v_cyc < 0) first_v_cyc = cyc;
      rec_n[0]++;
    end
    if (mi_v || mi_e) begin
      if (rec_n[1] < 16) begin
        rec_d[1][rec_n[1]] = mi_d; rec_v[1][rec_n[1]] = mi_v; rec_s[1][rec_n[1]] = mi_s;
        rec_e[1][rec_n[1]] = mi_e; rec_c[1][rec_n[1]] = mi_c;
      end
      rec_n[1]++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // trail: 0 low, 1 high, 2 pulse after last edge
  task automatic frame(input logic pol, input logic pha, input int nb, input int trail);
    cpol = pol; cpha = pha; sclk = pol;
    wclk(6);
    rec_n[0] = 0; rec_n[1] = 0; first_v_cyc = -1; edge8_cyc = -1;
    cs_n = 1'b0;
    wclk(HALF);
    for (int i = 0; i < nb; i++) begin
      logic mb, sb;
      mb = tx[0][i/8][7-(i%8)];
      sb = tx[1][i/8][7-(i%8)];
      if (!pha) begin
        mosi = mb; miso = sb; wclk(HALF);
        sclk = ~sclk; if (i == 7) edge8_cyc = cyc; wclk(HALF);
        sclk = ~sclk;
      end else begin
        sclk = ~sclk; mosi = mb; miso = sb; wclk(HALF);
        sclk = ~sclk; if (i == 7) edge8_cyc = cyc; wclk(HALF);
      end
    end
    wclk(1);
    case (trail)
      0: begin mosi = 1'b0; miso = 1'b0; end
      1: begin mosi = 1'b1; miso = 1'b1; end
      default: begin mosi = ~mosi; miso = ~miso; wclk(2); mosi = ~mosi; miso = ~miso; end
    endcase
    wclk(HALF);
    cs_n = 1'b1;
    wclk(2);
    // R8: clock and data activity outside the window
    for (int k = 0; k < 6; k++) begin
      sclk = ~sclk; mosi = k[0]; miso = ~k[0]; wclk(HALF);
    end
    wclk(10);
  endtask

  task automatic verify(input int nb, input string tag);
    int full, rem, n_exp;
    full = nb / 8; rem = nb % 8;
    n_exp = full + 1;
    for (int l = 0; l < 2; l++) begin
      check(rec_n[l] == n_exp, {tag, " R4 entry count"}, rec_n[l], n_exp);
      if (rec_n[l] == n_exp) begin
        for (int k = 0; k < full; k++) begin
          check(rec_v[l][k] && rec_d[l][k] == tx[l][k] && !rec_e[l][k] && rec_c[l][k] == 3'd0,
                {tag, (l == 0) ? " R3 R4 mosi byte" : " R9 miso byte"}, rec_d[l][k], tx[l][k]);
          check(rec_s[l][k] == (k == 0), {tag, " R5 sof"}, rec_s[l][k], (k == 0));
        end
        if (rem != 0) begin
          logic [7:0] pexp;
          pexp = tx[l][full] >> (8 - rem);
          check(rec_v[l][full] && rec_e[l][full] && rec_c[l][full] == 3'(rem) && rec_d[l][full] == pexp,
                {tag, " R6 partial"}, {rec_c[l][full], rec_d[l][full]}, {3'(rem), pexp});
          check(rec_s[l][full] == (full == 0), {tag, " R5 sof partial"}, rec_s[l][full], (full == 0));
        end else begin
          check(!rec_v[l][full] && rec_e[l][full] && rec_c[l][full] == 3'd0 && !rec_s[l][full],
                {tag, " R7 end marker"}, {rec_v[l][full], rec_e[l][full]}, 2'b01);
        end
      end
    end
    if (nb >= 8)
      check(first_v_cyc - edge8_cyc == 3, {tag, " R2 R1 strobe latency"}, first_v_cyc - edge8_cyc, 3);
  endtask

  initial begin
    int lens [9] = '{1, 3, 7, 8, 9, 16, 24, 32, 40};
    rec_n[0] = 0; rec_n[1] = 0;
    wclk(3);
    rst_n = 1'b1;
    wclk(2);
    // R10
    check({mo_d, mo_v, mo_s, mo_e, mo_c, mi_d, mi_v, mi_s, mi_e, mi_c} == '0, "R10 reset outputs",
          {mo_d, mi_d}, 0);

    // R3: trailing ones, both lanes differ (R9)
    tx[0][0] = 8'h55; tx[0][1] = 8'h00; tx[0][2] = 8'hFF; tx[0][3] = 8'hFF;
    tx[1][0] = 8'h33; tx[1][1] = 8'h37; tx[1][2] = 8'h0F; tx[1][3] = 8'hFF;
    for (int m = 0; m < 4; m++) begin
      frame(m[1], m[0], 32, 1);
      verify(32, "trail-ones R3");
    end
    tx[0][0] = 8'h33; tx[1][0] = 8'hFF;
    frame(1'b1, 1'b1, 8, 1);
    verify(8, "single R3");

    // sweep modes, lengths, trailing behaviour
    for (int m = 0; m < 4; m++) begin
      for (int li = 0; li < 9; li++) begin
        int nb;
        nb = lens[li];
        for (int k = 0; k < 8; k++) begin
          tx[0][k] = 8'((k * 59) ^ (nb * 7) ^ (m << 4));
          tx[1][k] = 8'((k * 23 + 5) ^ (nb * 3) ^ 8'hA6);
        end
        frame(m[1], m[0], nb, (m + li) % 3);
        verify(nb, "sweep R1");
      end
    end

    // R8: an aborted partial frame leaves no residue in the next frame
    tx[0][0] = 8'hC0; tx[1][0] = 8'h3F;
    frame(1'b0, 1'b0, 5, 1);
    verify(5, "abort R8");
    tx[0][0] = 8'hA5; tx[1][0] = 8'h5A; tx[0][1] = 8'h81; tx[1][1] = 8'h7E;
    frame(1'b0, 1'b0, 16, 2);
    verify(16, "after-abort R8");

    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule